// File: doc/BRIEF.md
# Selectable Carry-Less Multiplier Array

This block multiplies two 64-bit operands as polynomials over GF(2), so partial products are combined with XOR and no carries propagate. It returns the full 128-bit product. It is built as an array of identical lanes. Each lane takes one 128-bit word from operand vector A and one from operand vector B. It picks one 64-bit half of each word and places the 128-bit product in the matching lane of the result vector.

An 8-bit control byte chooses the halves, and the same byte applies to every lane. Bit 0 picks the half of A and bit 4 picks the half of B; the other six bits have no effect. A caller presents operands with `in_valid`. One clock later the registered result appears with `out_valid`. The block has no back-pressure and performs no modular reduction. The lane count is a parameter and may be 1, 2 or 4.

Top module: `clmul_array`

## Requirements
- R1: Control bit 0 chooses the A operand of each lane: value 0 takes bits [63:0] of the lane's 128-bit A word, and value 1 takes bits [127:64].
- R2: Control bit 4 chooses the B operand of each lane with the same encoding, applied to the lane's B word.
- R3: Control bits 1, 2, 3, 5, 6 and 7 have no effect on any result.
- R4: Bits [63:0] of each lane result equal the low 64 bits of the carry-less product of the two chosen operands.
- R5: Bits [126:64] of each lane result equal bits [126:64] of that same carry-less product.
- R6: Bit 127 of every lane result is zero.
- R7: Lane l (l = 0..LANES-1) occupies bits [128*l+127 : 128*l] of the A, B and result vectors. It uses only its own A and B words, and its low product word is at the lower address.
- R8: The one control byte governs every lane in the same way.
- R9: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R10: In a cycle where `in_valid` is low, the result register keeps its value whatever the operands and control carry.
- R11: A synchronous active-high reset clears `out_valid` and the whole result register.
- R12: When both chosen operands have bit 63 set, bit 126 of that lane result is set and bit 127 stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and control are present this cycle |
| in_a | input | 128*LANES | A operand vector, one 128-bit word per lane |
| in_b | input | 128*LANES | B operand vector, one 128-bit word per lane |
| in_ctrl | input | 8 | Half-select control byte, shared by all lanes |
| out_valid | output | 1 | Result vector is new this cycle |
| out_res | output | 128*LANES | Product vector, one 128-bit product per lane |

## Verification
Every result is due one rising edge after the edge that captured its operands. This means `out_valid` and `out_res` change exactly one cycle after `in_valid`. The bench drives inputs on the falling edge. It then compares outputs on the next falling edge, which is half a period after the capturing edge and before any new stimulus is applied. During idle cycles the bench puts fresh random data on the inputs. At the next falling edge it checks that the result is unchanged and that `out_valid` is low. Expected products come from a bit-serial shift-and-XOR model, so they are independent of the split-class method the design uses.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int WORD_W    = 64;
  localparam int LANE_W    = 2 * WORD_W;
  localparam int CTRL_W    = 8;
  localparam int SEL_A_BIT = 0;
  localparam int SEL_B_BIT = 4;
  localparam int NCLASS    = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  // Bit c of every group of NCLASS bits.
  function automatic word_t class_mask(input int c);
    word_t m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((i % NCLASS) == c);
    return m;
  endfunction

  // Full reversal: mirror each byte, then mirror the byte order.
  function automatic word_t rev_word(input word_t v);
    word_t t;
    for (int k = 0; k < WORD_W / 8; k++)
      for (int j = 0; j < 8; j++)
        t[8 * (WORD_W / 8 - 1 - k) + (7 - j)] = v[8 * k + j];
    return t;
  endfunction

  // Low word of the GF(2) product. Each operand is split into four
  // interleaved classes so that integer carries fall into bits of a
  // class that is masked off afterwards.
  function automatic word_t clmul_low(input word_t x, input word_t y);
    word_t xs [NCLASS];
    word_t ys [NCLASS];
    word_t acc;
    word_t res;
    for (int c = 0; c < NCLASS; c++) begin
      xs[c] = x & class_mask(c);
      ys[c] = y & class_mask(c);
    end
    res = '0;
    for (int c = 0; c < NCLASS; c++) begin
      acc = '0;
      for (int i = 0; i < NCLASS; i++)
        acc = acc ^ (xs[i] * ys[(c - i + NCLASS) % NCLASS]);
      res = res | (acc & class_mask(c));
    end
    return res;
  endfunction

  // High word: low product of mirrored operands, mirrored back, less one bit.
  function automatic word_t clmul_high(input word_t x, input word_t y);
    return rev_word(clmul_low(rev_word(x), rev_word(y))) >> 1;
  endfunction
endpackage

// File: rtl/clmul_opsel.sv
module clmul_opsel
  import clmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*LANE_W-1:0]     a_vec,
  input  logic [LANES*LANE_W-1:0]     b_vec,
  input  logic [CTRL_W-1:0]           ctrl,
  output logic [LANES-1:0][WORD_W-1:0] sel_a,
  output logic [LANES-1:0][WORD_W-1:0] sel_b
);
  logic a_hi;
  logic b_hi;

  assign a_hi = ctrl[SEL_A_BIT];
  assign b_hi = ctrl[SEL_B_BIT];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int BASE = l * LANE_W;
    assign sel_a[l] = a_hi ? a_vec[BASE + WORD_W +: WORD_W] : a_vec[BASE +: WORD_W];
    assign sel_b[l] = b_hi ? b_vec[BASE + WORD_W +: WORD_W] : b_vec[BASE +: WORD_W];
  end
endmodule

// File: rtl/clmul_lane.sv
module clmul_lane
  import clmul_pkg::*;
(
  input  logic [WORD_W-1:0] op_x,
  input  logic [WORD_W-1:0] op_y,
  output logic [LANE_W-1:0] prod
);
  logic [WORD_W-1:0] lo_w;
  logic [WORD_W-1:0] hi_w;

  assign lo_w = clmul_low(op_x, op_y);
  assign hi_w = clmul_high(op_x, op_y);
  assign prod = {hi_w, lo_w};
endmodule

// File: rtl/clmul_array.sv
module clmul_array
  import clmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  input  logic [CTRL_W-1:0]         in_ctrl,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   out_res
);
  localparam int VEC_W = LANES * LANE_W;

  // Chosen operands, named so the checker can see them.
  logic [LANES-1:0][WORD_W-1:0] sel_a_w;
  logic [LANES-1:0][WORD_W-1:0] sel_b_w;
  logic [VEC_W-1:0]             prod_w;
  logic                         load_w;

  assign load_w = in_valid;

  clmul_opsel #(.LANES(LANES)) u_sel (
    .a_vec (in_a),
    .b_vec (in_b),
    .ctrl  (in_ctrl),
    .sel_a (sel_a_w),
    .sel_b (sel_b_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    clmul_lane u_lane (
      .op_x (sel_a_w[l]),
      .op_y (sel_b_w[l]),
      .prod (prod_w[l * LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= load_w;
      if (load_w) out_res <= prod_w;
    end
  end
endmodule

// File: rtl/clmul_chk.sv
module clmul_chk
  import clmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic                          out_valid,
  input logic [LANES*LANE_W-1:0]       out_res,
  input logic [LANES-1:0][WORD_W-1:0]  sel_a,
  input logic [LANES-1:0][WORD_W-1:0]  sel_b
);
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_res));
  p_clear_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_res == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_top_zero_r6: assert property (@(posedge clk) disable iff (rst)
      out_res[l * LANE_W + LANE_W - 1] == 1'b0);
    p_bit0_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_res[l * LANE_W] == ($past(sel_a[l][0]) & $past(sel_b[l][0])));
    p_msb_pair_r12: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sel_a[l][WORD_W-1] && sel_b[l][WORD_W-1]) |=>
        (out_res[l * LANE_W + LANE_W - 2] && !out_res[l * LANE_W + LANE_W - 1]));
  end
endmodule

bind clmul_array clmul_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_res   (out_res),
  .sel_a     (sel_a_w),
  .sel_b     (sel_b_w)
);

// File: tb/tb_clmul_array.sv
module tb_clmul_array;
  localparam int LANES  = 2;
  localparam int W      = 64;
  localparam int LW     = 128;
  localparam int VW     = LANES * LW;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [VW-1:0] in_a;
  logic [VW-1:0] in_b;
  logic [7:0]    in_ctrl;
  logic          out_valid;
  logic [VW-1:0] out_res;

  int n_chk  = 0;
  int n_fail = 0;
  logic [VW-1:0] last_res;

  clmul_array #(.LANES(LANES)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_ctrl(in_ctrl), .out_valid(out_valid), .out_res(out_res)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bit-serial reference: XOR a shifted copy of x for each set bit of y.
  function automatic logic [LW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [LW-1:0] acc = '0;
    for (int i = 0; i < W; i++)
      if (y[i]) acc = acc ^ ({{W{1'b0}}, x} << i);
    return acc;
  endfunction

  function automatic logic [VW-1:0] expect_vec(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic [7:0] c);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      logic [W-1:0] xa, yb;
      xa = c[0] ? a[l*LW+W +: W] : a[l*LW +: W];
      yb = c[4] ? b[l*LW+W +: W] : b[l*LW +: W];
      r[l*LW +: LW] = ref_mul(xa, yb);
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [VW-1:0] rndvec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One valid operation, result compared on the following falling edge.
  task automatic run_op(input string tag, input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic [7:0] c);
    logic [VW-1:0] e;
    e = expect_vec(a, b, c);
    in_valid = 1'b1; in_a = a; in_b = b; in_ctrl = c;
    @(negedge clk);
    check({tag, " R9 out_valid"}, {127'd0, out_valid}, 128'd1);
    for (int l = 0; l < LANES; l++) begin
      check({tag, " R4/R7 low word"}, {64'd0, out_res[l*LW +: W]}, {64'd0, e[l*LW +: W]});
      check({tag, " R5/R8 high word"}, {64'd0, out_res[l*LW+W +: W]}, {64'd0, e[l*LW+W +: W]});
      check({tag, " R6 bit127"}, {127'd0, out_res[l*LW+LW-1]}, 128'd0);
    end
    last_res = out_res;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] a, b;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_a = '1; in_b = '1; in_ctrl = 8'hFF;
    @(negedge clk); @(negedge clk);
    // R11 reset state
    check("R11 reset out_valid", {127'd0, out_valid}, 128'd0);
    check("R11 reset result", out_res[LW-1:0], 128'd0);
    rst = 1'b0;

    // Corner operands
    run_op("zero", '0, rndvec(), 8'h11);
    run_op("all-ones", '1, '1, 8'h00);
    a = '0; b = '0;
    for (int l = 0; l < LANES; l++) begin
      a[l*LW+W-1] = 1'b1; b[l*LW+W-1] = 1'b1;
    end
    run_op("R12 msb pair", a, b, 8'h00);
    check("R12 bit126", {127'd0, out_res[LW-2]}, 128'd1);
    check("R12 bit127", {127'd0, out_res[LW-1]}, 128'd0);

    // R1/R2 each half selection; R3 junk bits set
    a = rndvec(); b = rndvec();
    run_op("R1 A low R2 B low", a, b, 8'h00);
    run_op("R1 A high", a, b, 8'h01);
    run_op("R2 B high", a, b, 8'h10);
    run_op("R1 R2 both high", a, b, 8'h11);
    run_op("R3 junk bits lowsel", a, b, 8'hEE);
    run_op("R3 junk bits highsel", a, b, 8'hFF);

    // R7 lane isolation: one lane zero, other random
    a = rndvec(); b = rndvec();
    a[LW-1:0] = '0;
    run_op("R7 lane isolation", a, b, 8'h11);
    check("R7 lane0 zero", out_res[LW-1:0], 128'd0);

    // R10 idle holds result while inputs churn
    in_valid = 1'b0; in_a = rndvec(); in_b = rndvec(); in_ctrl = 8'h5A;
    @(negedge clk);
    check("R9 idle out_valid", {127'd0, out_valid}, 128'd0);
    for (int l = 0; l < LANES; l++)
      check("R10 hold", out_res[l*LW +: LW], last_res[l*LW +: LW]);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      a = rndvec(); b = rndvec();
      if (n % 7 == 0) a[W-1] = 1'b1;
      run_op("random", a, b, 8'($urandom()));
    end

    // R11 reset mid-run after a valid result
    run_op("pre-reset", '1, rndvec(), 8'h10);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R11 mid reset out_valid", {127'd0, out_valid}, 128'd0);
    for (int l = 0; l < LANES; l++)
      check("R11 mid reset result", out_res[l*LW +: LW], 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule